// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Broadcaster

This block gathers service requests from a group of timer channels and presents them as a single interrupt level on a shared 8-line request bus. Each channel owns a pending flag, raised by a one-cycle set pulse from its timing logic, and an enable bit written by software. When at least one channel has both its flag and its enable bit set, the block asserts a request at the module-wide level held in a 5-bit level register.

The bus carries 32 levels on 8 wires by dividing time into four repeating slots. An external 2-bit slot code says which slot is current. The request line is driven only in the slot whose number equals the upper two bits of the level. In that slot, the line whose index equals the lower three bits of the level is asserted. There is no priority between channels: any number of enabled, pending channels together produce one request at the shared level.

Software reaches three registers through a single-cycle write port and a combinational read port, using a 2-bit address. A pending flag is cleared by writing 0 to its bit in the status register.

Top module: `irq_level_bcast`

## Requirements
- R1: A synchronous active-high reset clears all pending flags and all enable bits, and sets the level to 0. During and after reset the bus reads 0.
- R2: A 1 on `chanSet[i]` at a clock edge sets pending flag i. The flag then reads back as 1 in status bit i at address 1.
- R3: A write to address 0 loads the enable register from the write data. Address 0 reads back the stored value.
- R4: If no channel has both its pending flag and its enable bit set, the bus is 0 in every slot.
- R5: A write to address 2 loads the level from write-data bits 4:0. Address 2 reads back the level in bits 4:0, with all higher bits 0.
- R6: While a request is active, the bus equals a one-hot value with bit level[2:0] set when `slotSel` equals level[4:3], and 0 in every other slot. Slot codes 0, 1, 2 and 3 carry levels 7:0, 15:8, 23:16 and 31:24.
- R7: Several enabled, pending channels produce the same single asserted line as one channel does. At most one bus line is ever high.
- R8: A write to address 1 clears every flag whose write-data bit is 0 and leaves every flag whose write-data bit is 1 unchanged. It never sets a flag.
- R9: If a set pulse arrives in the same cycle as a clearing write to that flag, the flag ends up set.
- R10: A write to address 3 changes no register, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| chanSet | input | NUM_CH | Per-channel set pulses from the timing logic |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 enable, 1 status, 2 level, 3 unused |
| regWrData | input | NUM_CH | Register write data |
| regRdData | output | NUM_CH | Register read data, combinational on regAddr |
| slotSel | input | 2 | Current bus time slot |
| irqBus | output | 8 | Request bus for the current slot |

## Verification
The assertions assume that the slot code and the register inputs are stable across each rising edge, and that the set pulses are synchronous to the bus clock. They also assume that the level register holds a legal value, which is true because every 5-bit value is legal. The stimulus changes every input only on the falling edge. It holds each set pulse and each write for exactly one cycle, and it samples the bus and the read port half a cycle later. A separate case drives a set pulse together with a clearing write in the same cycle, so the rule that the pulse wins is exercised directly rather than assumed.

// File: rtl/irq_bcast_pkg.sv
package irq_bcast_pkg;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_LEVEL  = 2'd2,
    ADDR_SPARE  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic     loadEnable;
    logic     clearStatus;
    logic     loadLevel;
    regAddr_e readSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_bcast_ctrl.sv
module irq_bcast_ctrl
  import irq_bcast_pkg::*;
(
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  output ctrlStrobe_t strobe
);

  regAddr_e addrDec;

  always_comb begin
    addrDec            = regAddr_e'(regAddr);
    strobe.loadEnable  = regWr && (addrDec == ADDR_ENABLE);
    strobe.clearStatus = regWr && (addrDec == ADDR_STATUS);
    strobe.loadLevel   = regWr && (addrDec == ADDR_LEVEL);
    strobe.readSel     = addrDec;
  end

endmodule

// File: rtl/irq_bcast_datapath.sv
module irq_bcast_datapath
  import irq_bcast_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int LEVEL_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_CH-1:0]  wrData,
  input  logic [NUM_CH-1:0]  chanSet,
  output logic [NUM_CH-1:0]  rdData,
  output logic [NUM_CH-1:0]  enableQ,
  output logic [NUM_CH-1:0]  flagQ,
  output logic [LEVEL_W-1:0] levelQ,
  output logic               reqActive
);

  logic [NUM_CH-1:0] flagD;

  // per-channel flag next state: a set pulse beats a clearing write
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    always_comb begin
      flagD[g] = chanSet[g] | (flagQ[g] & ~(strobe.clearStatus & ~wrData[g]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ   <= '0;
      enableQ <= '0;
      levelQ  <= '0;
    end else begin
      flagQ <= flagD;
      if (strobe.loadEnable) enableQ <= wrData;
      if (strobe.loadLevel)  levelQ  <= wrData[LEVEL_W-1:0];
    end
  end

  assign reqActive = |(flagQ & enableQ);

  always_comb begin
    unique case (strobe.readSel)
      ADDR_ENABLE: rdData = enableQ;
      ADDR_STATUS: rdData = flagQ;
      ADDR_LEVEL:  rdData = {{(NUM_CH-LEVEL_W){1'b0}}, levelQ};
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_slot_drive.sv
module irq_slot_drive #(
  parameter int BUS_W   = 8,
  parameter int SLOT_W  = 2,
  parameter int LINE_W  = 3,
  parameter int LEVEL_W = 5
) (
  input  logic               reqActive,
  input  logic [LEVEL_W-1:0] level,
  input  logic [SLOT_W-1:0]  slotSel,
  output logic [BUS_W-1:0]   irqBus
);

  logic slotHit;
  assign slotHit = reqActive && (level[LEVEL_W-1:LINE_W] == slotSel);

  for (genvar g = 0; g < BUS_W; g++) begin : g_line
    assign irqBus[g] = slotHit && (level[LINE_W-1:0] == LINE_W'(g));
  end

endmodule

// File: rtl/irq_level_bcast.sv
module irq_level_bcast
  import irq_bcast_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int BUS_W     = 8,
  parameter int NUM_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH-1:0]             chanSet,
  input  logic                          regWr,
  input  logic [1:0]                    regAddr,
  input  logic [NUM_CH-1:0]             regWrData,
  output logic [NUM_CH-1:0]             regRdData,
  input  logic [$clog2(NUM_SLOTS)-1:0]  slotSel,
  output logic [BUS_W-1:0]              irqBus
);

  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int LINE_W  = $clog2(BUS_W);
  localparam int LEVEL_W = SLOT_W + LINE_W;

  ctrlStrobe_t        strobe;
  logic [NUM_CH-1:0]  enableQ;
  logic [NUM_CH-1:0]  flagQ;
  logic [LEVEL_W-1:0] levelQ;
  logic               reqActive;

  irq_bcast_ctrl u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irq_bcast_datapath #(
    .NUM_CH  (NUM_CH),
    .LEVEL_W (LEVEL_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (regWrData),
    .chanSet   (chanSet),
    .rdData    (regRdData),
    .enableQ   (enableQ),
    .flagQ     (flagQ),
    .levelQ    (levelQ),
    .reqActive (reqActive)
  );

  irq_slot_drive #(
    .BUS_W   (BUS_W),
    .SLOT_W  (SLOT_W),
    .LINE_W  (LINE_W),
    .LEVEL_W (LEVEL_W)
  ) u_drive (
    .reqActive (reqActive),
    .level     (levelQ),
    .slotSel   (slotSel),
    .irqBus    (irqBus)
  );

endmodule

// File: rtl/irq_level_bcast_chk.sv
module irq_level_bcast_chk #(
  parameter int NUM_CH  = 16,
  parameter int BUS_W   = 8,
  parameter int SLOT_W  = 2,
  parameter int LINE_W  = 3,
  parameter int LEVEL_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CH-1:0]  chanSet,
  input logic [SLOT_W-1:0]  slotSel,
  input logic [BUS_W-1:0]   irqBus,
  input logic [NUM_CH-1:0]  flagQ,
  input logic [NUM_CH-1:0]  enableQ,
  input logic [LEVEL_W-1:0] levelQ
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flagQ == '0 && enableQ == '0 && levelQ == '0 && irqBus == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|chanSet) |=> ((flagQ & $past(chanSet)) == $past(chanSet)));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((flagQ & enableQ) == '0) |-> (irqBus == '0));

  // R6
  slot_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (slotSel != levelQ[LEVEL_W-1:LINE_W]) |-> (irqBus == '0));

  // R6
  slot_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ((|(flagQ & enableQ)) && slotSel == levelQ[LEVEL_W-1:LINE_W])
      |-> (irqBus == (BUS_W'(1) << levelQ[LINE_W-1:0])));

  // R7
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irqBus));

endmodule

bind irq_level_bcast irq_level_bcast_chk #(
  .NUM_CH  (NUM_CH),
  .BUS_W   (BUS_W),
  .SLOT_W  (SLOT_W),
  .LINE_W  (LINE_W),
  .LEVEL_W (LEVEL_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .chanSet (chanSet),
  .slotSel (slotSel),
  .irqBus  (irqBus),
  .flagQ   (flagQ),
  .enableQ (enableQ),
  .levelQ  (levelQ)
);

// File: tb/irq_level_bcast_tb.sv
`timescale 1ns/1ps
module irq_level_bcast_tb;

  localparam int NUM_CH = 16;
  localparam int BUS_W  = 8;
  localparam int NVEC   = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [NUM_CH-1:0] chanSet;
  logic              regWr;
  logic [1:0]        regAddr;
  logic [NUM_CH-1:0] regWrData;
  logic [NUM_CH-1:0] regRdData;
  logic [1:0]        slotSel;
  logic [BUS_W-1:0]  irqBus;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  irq_level_bcast u_dut (
    .clk       (clk),
    .rst       (rst),
    .chanSet   (chanSet),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .slotSel   (slotSel),
    .irqBus    (irqBus)
  );

  // {level[4:0], enable[15:0], setMask[15:0], slot[1:0], expectedBus[7:0]}
  localparam logic [46:0] VEC [NVEC] = '{
    {5'd0,  16'h0001, 16'h0001, 2'd0, 8'h01},
    {5'd9,  16'h00F0, 16'h0010, 2'd1, 8'h02},
    {5'd9,  16'h00F0, 16'h0010, 2'd0, 8'h00},
    {5'd23, 16'hFFFF, 16'h8001, 2'd2, 8'h80},
    {5'd31, 16'h000F, 16'h00F0, 2'd3, 8'h00},
    {5'd26, 16'h0100, 16'h0100, 2'd3, 8'h04},
    {5'd26, 16'h0100, 16'h0100, 2'd2, 8'h00},
    {5'd12, 16'h1234, 16'h0204, 2'd1, 8'h10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [NUM_CH-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [NUM_CH-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic [NUM_CH-1:0] m);
    @(negedge clk);
    chanSet = m;
    @(negedge clk);
    chanSet = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] rd;
    rst = 1'b1; chanSet = '0; regWr = 1'b0; regAddr = 2'd0;
    regWrData = '0; slotSel = 2'd0;
    doReset();

    // R1 reset state
    regRead(2'd0, rd); check("R1 enable", 32'(rd), 32'h0);
    regRead(2'd1, rd); check("R1 status", 32'(rd), 32'h0);
    regRead(2'd2, rd); check("R1 level",  32'(rd), 32'h0);
    check("R1 bus", 32'(irqBus), 32'h0);

    // vector table: R6 slot mapping, R4 gating, R7 combining
    for (int i = 0; i < NVEC; i++) begin
      regWrite(2'd1, '0);
      regWrite(2'd2, NUM_CH'(VEC[i][46:42]));
      regWrite(2'd0, VEC[i][41:26]);
      pulse(VEC[i][25:10]);
      slotSel = VEC[i][9:8];
      #1;
      check($sformatf("R6/R4/R7 vector %0d", i), 32'(irqBus), 32'(VEC[i][7:0]));
    end

    doReset();
    // R3 enable readback
    regWrite(2'd0, 16'hA5C3);
    regRead(2'd0, rd); check("R3 enable readback", 32'(rd), 32'hA5C3);

    // R5 level width
    regWrite(2'd2, 16'hFFFF);
    regRead(2'd2, rd); check("R5 level readback", 32'(rd), 32'h001F);

    // R2 set pulse
    pulse(16'h00FF);
    regRead(2'd1, rd); check("R2 status after pulse", 32'(rd), 32'h00FF);

    // R8 write-zero clears, write-one keeps, never sets
    regWrite(2'd1, 16'hFF0F);
    regRead(2'd1, rd); check("R8 partial clear", 32'(rd), 32'h000F);

    // R9 set pulse coincides with clear
    @(negedge clk);
    regWr = 1'b1; regAddr = 2'd1; regWrData = 16'h0000; chanSet = 16'h0010;
    @(negedge clk);
    regWr = 1'b0; chanSet = '0;
    regRead(2'd1, rd); check("R9 pulse beats clear", 32'(rd), 32'h0010);

    // R4 pending flag but enable bit 4 off: bus quiet in all slots
    regWrite(2'd0, 16'hFFEF);
    for (int s = 0; s < 4; s++) begin
      slotSel = 2'(s);
      #1;
      check($sformatf("R4 disabled slot %0d", s), 32'(irqBus), 32'h0);
    end

    // R10 spare address
    regWrite(2'd3, 16'hFFFF);
    regRead(2'd0, rd); check("R10 enable kept", 32'(rd), 32'hFFEF);
    regRead(2'd1, rd); check("R10 status kept", 32'(rd), 32'h0010);
    regRead(2'd2, rd); check("R10 level kept",  32'(rd), 32'h001F);
    regRead(2'd3, rd); check("R10 spare reads zero", 32'(rd), 32'h0);

    // R7 two channels at level 31, slot 3
    regWrite(2'd0, 16'hFFFF);
    pulse(16'h0300);
    slotSel = 2'd3;
    #1;
    check("R7 combined request", 32'(irqBus), 32'h80);

    // R1 reset mid-run clears bus and registers
    doReset();
    #1;
    check("R1 bus after reset", 32'(irqBus), 32'h0);
    regRead(2'd1, rd); check("R1 status after reset", 32'(rd), 32'h0);
    regRead(2'd2, rd); check("R1 level after reset",  32'(rd), 32'h0);

    doneFlag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule